// File: doc/BRIEF.md
# Pad-Side Configuration and Signal Steering Cell

This cell sits next to one general-purpose I/O pad. It keeps a local copy of the pad's 13-bit configuration word. That word mirrors a register held elsewhere on the management side. The copy is taken only on the clock edge where a transfer strobe is high. Because of this, the pad's static controls change only at known instants, however much the mirror bus moves between strobes.

The stored word does two jobs:

- It drives the pad's static controls: digital drive mode, input threshold select, slew limit, three analog bus bits, an IB mode select, input disable and hold value. Each of these is a register output.
- It decides who owns the three dynamic pad signals (output value, output enable and input value): the user-side port or the management side.

The management side comes in two variants, selected by a parameter:

- **Full-control variant.** Management gets separate output, output-enable and input signals.
- **Single-wire variant.** Management gets one shared wire. That wire acts as the pad output or as the pad input, depending on the stored output-disable bit and the drive mode.
  - In the pull-up drive mode the cell forces the pad output value itself. It forces it to the inverse of drive-mode bit 0.
  - The pull-down drive mode works the same way.
  - In both pull modes the shared wire carries the pad input.

The single wire is modelled as a split pair: `mgmt_out` carries the value management drives, and `mgmt_in` carries the value the wire holds.

Top module: `pad_ctl_cell`

## Requirements
- R1: The stored word after reset depends on the variant.
  - Single-wire variant: 13'h0403, which is drive mode 001, output disable 1, management enable 1, and all other bits 0.
  - Full-control variant: 13'h1801, which is drive mode 110, output disable 0, management enable 1.
  - Reset is synchronous and active high.
- R2: When `xfer` is high at a rising clock edge (with reset low), the stored word takes the value of `cfg_mirror`. The static outputs show the new word after that edge.
- R3: Changes on `cfg_mirror` while `xfer` is low leave every output unchanged.
- R4: When reset and `xfer` are high at the same edge, the reset default is stored, not the mirror value.
- R5: With management enable (bit 0) at 0:
  - `pad_out` follows `usr_out` and `pad_oe` follows `usr_oe`.
  - `usr_in` follows `pad_in`.
  - `mgmt_in` is 0.
- R6: With management enable at 1, `usr_in` is 0 and the user output signals have no effect on the pad.
- R7: Single-wire variant, management enable 1, output disable (bit 1) 0, drive mode not 010 or 011:
  - `pad_oe` is 1.
  - `pad_out` follows `mgmt_out`.
  - `mgmt_in` returns the driven wire value `mgmt_out`.
- R8: Single-wire variant, management enable 1, output disable 1:
  - `pad_oe` is 0.
  - `mgmt_in` follows `pad_in`.
- R9: Single-wire variant, management enable 1, drive mode (bits 12:10) 010 or 011:
  - `pad_out` is the inverse of bit 10: 1 for 010, 0 for 011.
  - `mgmt_in` follows `pad_in`.
  - `pad_oe` is the inverse of output disable.
- R10: Full-control variant, management enable 1: `pad_out` follows `mgmt_out`, `pad_oe` follows `mgmt_oe` and `mgmt_in` follows `pad_in`. Output disable and drive mode have no effect on these signals.
- R11: The static outputs map from the stored word as follows.

| Stored bits | Output |
|---|---|
| [12:10] | `pad_dm` |
| [9] | `pad_trip_sel` |
| [8] | `pad_slow` |
| [7] | `pad_abus_pol` |
| [6] | `pad_abus_sel` |
| [5] | `pad_abus_en` |
| [4] | `pad_ib_sel` |
| [3] | `pad_in_dis` |
| [2] | `pad_hold` |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer | input | 1 | Transfer strobe; copies the mirror word |
| cfg_mirror | input | 13 | Mirrored configuration word |
| usr_out | input | 1 | User-side output value |
| usr_oe | input | 1 | User-side output enable |
| usr_in | output | 1 | Pad input seen by the user side |
| mgmt_out | input | 1 | Management output value (driven side of the single wire) |
| mgmt_oe | input | 1 | Management output enable (full-control variant only) |
| mgmt_in | output | 1 | Value returned to management |
| pad_in | input | 1 | Input value from the pad |
| pad_out | output | 1 | Output value to the pad |
| pad_oe | output | 1 | Output enable to the pad |
| pad_dm | output | 3 | Digital drive mode |
| pad_trip_sel | output | 1 | Input trip point select |
| pad_slow | output | 1 | Slow slew select |
| pad_abus_pol | output | 1 | Analog bus polarity |
| pad_abus_sel | output | 1 | Analog bus select |
| pad_abus_en | output | 1 | Analog bus enable |
| pad_ib_sel | output | 1 | IB mode select |
| pad_in_dis | output | 1 | Input disable |
| pad_hold | output | 1 | Hold value |

## Verification
Directed words cover each ownership case:

- user ownership;
- the single-wire output role;
- the single-wire input role;
- both pull modes.

Each of these words is loaded into both variants at once. Each word is then exercised with several combinations of the user, management and pad input values, which separates a signal that truly follows its source from one that is stuck or routed from the wrong side.

Bursts of mirror activity without a strobe, and a strobe that coincides with reset, separate shadowing from transparent pass-through. Random words then mix all field values, so that any misplaced bit in the static mapping is exposed.

// File: rtl/pad_cfg_pkg.sv
`timescale 1ns/1ps
package pad_cfg_pkg;

    localparam int CFG_W = 13;
    localparam int DM_W  = 3;

    localparam logic [DM_W-1:0] DM_INPUT  = 3'b001;
    localparam logic [DM_W-1:0] DM_PULLUP = 3'b010;
    localparam logic [DM_W-1:0] DM_PULLDN = 3'b011;
    localparam logic [DM_W-1:0] DM_DRIVE  = 3'b110;

    // Field order fixes the bit positions of the word (MSB first).
    typedef struct packed {
        logic [DM_W-1:0] dm;        // [12:10]
        logic            trip_sel;  // [9]
        logic            slow;      // [8]
        logic            abus_pol;  // [7]
        logic            abus_sel;  // [6]
        logic            abus_en;   // [5]
        logic            ib_sel;    // [4]
        logic            in_dis;    // [3]
        logic            hold;      // [2]
        logic            out_dis;   // [1]
        logic            mgmt_en;   // [0]
    } pad_cfg_t;

    typedef struct packed {
        logic out;
        logic oe;
        logic in;
    } pad_dyn_t;

    function automatic pad_cfg_t reset_word(input bit full_mgmt);
        pad_cfg_t w;
        w         = '0;
        w.mgmt_en = 1'b1;
        if (full_mgmt) begin
            w.dm      = DM_DRIVE;
            w.out_dis = 1'b0;
        end else begin
            w.dm      = DM_INPUT;
            w.out_dis = 1'b1;
        end
        return w;
    endfunction

    function automatic logic is_pull(input logic [DM_W-1:0] dm);
        return (dm == DM_PULLUP) || (dm == DM_PULLDN);
    endfunction

endpackage

// File: rtl/pad_cfg_shadow.sv
`timescale 1ns/1ps
module pad_cfg_shadow
    import pad_cfg_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     xfer,
    input  pad_cfg_t mirror,
    output pad_cfg_t cfg_q
);

    localparam pad_cfg_t DEF_WORD = reset_word(FULL_MGMT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= DEF_WORD;
        end else if (xfer) begin
            cfg_q <= mirror;
        end
    end

    a_r1_reset_default: assert property (@(posedge clk)
        rst |=> (cfg_q == DEF_WORD));

    a_r2_load_on_strobe: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (cfg_q == $past(mirror)));

    a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(cfg_q));

endmodule

// File: rtl/pad_sig_route.sv
`timescale 1ns/1ps
module pad_sig_route
    import pad_cfg_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  pad_cfg_t cfg,
    input  logic     usr_out,
    input  logic     usr_oe,
    output logic     usr_in,
    input  logic     mgmt_out,
    input  logic     mgmt_oe,
    output logic     mgmt_in,
    input  logic     pad_in,
    output logic     pad_out,
    output logic     pad_oe
);

    pad_dyn_t mside;

    generate
        if (FULL_MGMT) begin : g_full
            assign mside.out = mgmt_out;
            assign mside.oe  = mgmt_oe;
            assign mside.in  = pad_in;

            logic unused_cfg;
            assign unused_cfg = cfg.out_dis;

            a_r10_full_control: assert property (@(posedge clk) disable iff (rst)
                cfg.mgmt_en |-> (pad_oe == mgmt_oe) && (pad_out == mgmt_out)
                                && (mgmt_in == pad_in));
        end else begin : g_wire
            logic pull;
            logic in_role;

            assign pull      = is_pull(cfg.dm);
            assign in_role   = cfg.out_dis | pull;
            assign mside.out = pull ? ~cfg.dm[0] : mgmt_out;
            assign mside.oe  = ~cfg.out_dis;
            assign mside.in  = in_role ? pad_in : mgmt_out;

            logic unused_oe;
            assign unused_oe = mgmt_oe;

            a_r8_input_role: assert property (@(posedge clk) disable iff (rst)
                (cfg.mgmt_en && cfg.out_dis) |-> (!pad_oe && (mgmt_in == pad_in)));

            a_r9_pullup_forces: assert property (@(posedge clk) disable iff (rst)
                (cfg.mgmt_en && cfg.dm == DM_PULLUP) |-> pad_out);

            a_r9_pulldn_forces: assert property (@(posedge clk) disable iff (rst)
                (cfg.mgmt_en && cfg.dm == DM_PULLDN) |-> !pad_out);
        end
    endgenerate

    always_comb begin
        if (cfg.mgmt_en) begin
            pad_out = mside.out;
            pad_oe  = mside.oe;
            mgmt_in = mside.in;
            usr_in  = 1'b0;
        end else begin
            pad_out = usr_out;
            pad_oe  = usr_oe;
            mgmt_in = 1'b0;
            usr_in  = pad_in;
        end
    end

    a_r5_user_owns: assert property (@(posedge clk) disable iff (rst)
        !cfg.mgmt_en |-> (pad_out == usr_out) && (pad_oe == usr_oe) && !mgmt_in);

    a_r6_user_gated: assert property (@(posedge clk) disable iff (rst)
        cfg.mgmt_en |-> !usr_in);

endmodule

// File: rtl/pad_ctl_cell.sv
`timescale 1ns/1ps
module pad_ctl_cell
    import pad_cfg_pkg::*;
#(
    parameter bit FULL_MGMT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer,
    input  logic [CFG_W-1:0] cfg_mirror,
    input  logic             usr_out,
    input  logic             usr_oe,
    output logic             usr_in,
    input  logic             mgmt_out,
    input  logic             mgmt_oe,
    output logic             mgmt_in,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic [DM_W-1:0]  pad_dm,
    output logic             pad_trip_sel,
    output logic             pad_slow,
    output logic             pad_abus_pol,
    output logic             pad_abus_sel,
    output logic             pad_abus_en,
    output logic             pad_ib_sel,
    output logic             pad_in_dis,
    output logic             pad_hold
);

    pad_cfg_t cfg_q;

    pad_cfg_shadow #(.FULL_MGMT(FULL_MGMT)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .xfer   (xfer),
        .mirror (pad_cfg_t'(cfg_mirror)),
        .cfg_q  (cfg_q)
    );

    pad_sig_route #(.FULL_MGMT(FULL_MGMT)) u_route (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg_q),
        .usr_out  (usr_out),
        .usr_oe   (usr_oe),
        .usr_in   (usr_in),
        .mgmt_out (mgmt_out),
        .mgmt_oe  (mgmt_oe),
        .mgmt_in  (mgmt_in),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    // R11: static controls come straight from the shadow register
    assign pad_dm       = cfg_q.dm;
    assign pad_trip_sel = cfg_q.trip_sel;
    assign pad_slow     = cfg_q.slow;
    assign pad_abus_pol = cfg_q.abus_pol;
    assign pad_abus_sel = cfg_q.abus_sel;
    assign pad_abus_en  = cfg_q.abus_en;
    assign pad_ib_sel   = cfg_q.ib_sel;
    assign pad_in_dis   = cfg_q.in_dis;
    assign pad_hold     = cfg_q.hold;

    a_r11_static_quiet: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable({pad_dm, pad_trip_sel, pad_slow, pad_abus_pol,
                           pad_abus_sel, pad_abus_en, pad_ib_sel,
                           pad_in_dis, pad_hold}));

endmodule

// File: tb/tb_pad_ctl_cell.sv
`timescale 1ns/1ps
module tb_pad_ctl_cell;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer = 1'b0;
    logic [12:0] cfg_mirror = '0;
    logic        usr_out = 0, usr_oe = 0, mgmt_out = 0, mgmt_oe = 0, pad_in = 0;

    logic        g_usr_in, g_mgmt_in, g_pad_out, g_pad_oe;
    logic [2:0]  g_dm;
    logic        g_trip, g_slow, g_pol, g_sel, g_en, g_ib, g_indis, g_hold;
    logic        f_usr_in, f_mgmt_in, f_pad_out, f_pad_oe;
    logic [2:0]  f_dm;
    logic        f_trip, f_slow, f_pol, f_sel, f_en, f_ib, f_indis, f_hold;

    int checks = 0;
    int fails  = 0;
    logic [12:0] model_g, model_f;

    localparam logic [12:0] DEF_G = 13'h0403;
    localparam logic [12:0] DEF_F = 13'h1801;

    always #4 clk = ~clk;   // 125 MHz

    pad_ctl_cell #(.FULL_MGMT(1'b0)) dut (
        .clk(clk), .rst(rst), .xfer(xfer), .cfg_mirror(cfg_mirror),
        .usr_out(usr_out), .usr_oe(usr_oe), .usr_in(g_usr_in),
        .mgmt_out(mgmt_out), .mgmt_oe(mgmt_oe), .mgmt_in(g_mgmt_in),
        .pad_in(pad_in), .pad_out(g_pad_out), .pad_oe(g_pad_oe),
        .pad_dm(g_dm), .pad_trip_sel(g_trip), .pad_slow(g_slow),
        .pad_abus_pol(g_pol), .pad_abus_sel(g_sel), .pad_abus_en(g_en),
        .pad_ib_sel(g_ib), .pad_in_dis(g_indis), .pad_hold(g_hold)
    );

    pad_ctl_cell #(.FULL_MGMT(1'b1)) dut_full (
        .clk(clk), .rst(rst), .xfer(xfer), .cfg_mirror(cfg_mirror),
        .usr_out(usr_out), .usr_oe(usr_oe), .usr_in(f_usr_in),
        .mgmt_out(mgmt_out), .mgmt_oe(mgmt_oe), .mgmt_in(f_mgmt_in),
        .pad_in(pad_in), .pad_out(f_pad_out), .pad_oe(f_pad_oe),
        .pad_dm(f_dm), .pad_trip_sel(f_trip), .pad_slow(f_slow),
        .pad_abus_pol(f_pol), .pad_abus_sel(f_sel), .pad_abus_en(f_en),
        .pad_ib_sel(f_ib), .pad_in_dis(f_indis), .pad_hold(f_hold)
    );

    // Expected {pad_out, pad_oe, usr_in, mgmt_in, static[10:0]}
    function automatic logic [14:0] expect_of(input logic [12:0] c, input bit full,
                                              input logic uo, uoe, mo, moe, pin);
        logic po, poe, ui, mi, pull;
        pull = (c[12:10] == 3'b010) || (c[12:10] == 3'b011);
        if (!c[0]) begin
            po = uo;  poe = uoe; ui = pin; mi = 1'b0;           // R5
        end else if (full) begin
            po = mo;  poe = moe; ui = 1'b0; mi = pin;           // R10, R6
        end else begin
            po  = pull ? ~c[10] : mo;                           // R9, R7
            poe = ~c[1];                                        // R7, R8
            mi  = (c[1] | pull) ? pin : mo;
            ui  = 1'b0;                                         // R6
        end
        return {po, poe, ui, mi, c[12:2]};                      // R11 mapping
    endfunction

    task automatic check_all(input string tag);
        logic [14:0] ag, af, eg, ef;
        ag = {g_pad_out, g_pad_oe, g_usr_in, g_mgmt_in, g_dm, g_trip, g_slow,
              g_pol, g_sel, g_en, g_ib, g_indis, g_hold};
        af = {f_pad_out, f_pad_oe, f_usr_in, f_mgmt_in, f_dm, f_trip, f_slow,
              f_pol, f_sel, f_en, f_ib, f_indis, f_hold};
        eg = expect_of(model_g, 1'b0, usr_out, usr_oe, mgmt_out, mgmt_oe, pad_in);
        ef = expect_of(model_f, 1'b1, usr_out, usr_oe, mgmt_out, mgmt_oe, pad_in);
        checks += 2;
        if (ag !== eg) begin
            fails++;
            $display("FAIL %s single-wire: actual %h expected %h (cfg %h)", tag, ag, eg, model_g);
        end
        if (af !== ef) begin
            fails++;
            $display("FAIL %s full-control: actual %h expected %h (cfg %h)", tag, af, ef, model_f);
        end
    endtask

    task automatic load_word(input logic [12:0] w, input bit with_rst);
        @(negedge clk);
        cfg_mirror = w; xfer = 1'b1; rst = with_rst;
        @(negedge clk);
        xfer = 1'b0; rst = 1'b0;
        model_g = with_rst ? DEF_G : w;
        model_f = with_rst ? DEF_F : w;
        #1;
    endtask

    task automatic set_dyn(input logic [4:0] v);
        {usr_out, usr_oe, mgmt_out, mgmt_oe, pad_in} = v;
        #1;
    endtask

    task automatic sweep(input logic [12:0] w, input string tag);
        load_word(w, 1'b0);
        check_all(tag);
        set_dyn(5'b10101); check_all(tag);
        set_dyn(5'b01010); check_all(tag);
        set_dyn(5'b11111); check_all(tag);
        set_dyn(5'b00000); check_all(tag);
        set_dyn(5'b10011); check_all(tag);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired before test end");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        model_g = DEF_G;
        model_f = DEF_F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_all("R1");
        set_dyn(5'b11011); check_all("R1");

        sweep(13'b000_0000_0000_0_0, "R5");              // user ownership
        sweep(13'b110_0000_0000_0_1, "R7");              // wire output role
        sweep(13'b001_0000_0000_1_1, "R8");              // wire input role
        sweep(13'b010_0000_0000_1_1, "R9");              // pull-up
        sweep(13'b011_0000_0000_1_1, "R9");              // pull-down
        sweep(13'b111_0000_0000_1_1, "R10");             // full ignores out_dis
        sweep(13'b101_1111_1111_0_1, "R6");              // mgmt owns, users toggle

        // R2 and R11: walking one through the static field
        for (int b = 2; b < 13; b++) begin
            load_word(13'd1 << b, 1'b0);
            check_all("R11");
        end
        load_word(13'h155A, 1'b0);
        check_all("R2");

        // R3: mirror activity without a strobe
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cfg_mirror = 13'($urandom);
            #1;
            check_all("R3");
        end

        // R4: reset coinciding with strobe
        load_word(13'h0AAC, 1'b1);
        check_all("R4");

        // Random words and dynamic patterns
        for (int i = 0; i < 200; i++) begin
            load_word(13'($urandom), 1'b0);
            for (int k = 0; k < 4; k++) begin
                set_dyn(5'($urandom));
                check_all("R11");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule